// File: doc/BRIEF.md
# Leaf Page-Table Entry Permission Checker

This block judges one page-table entry that a hardware walker has just fetched. From the entry, the requesting privilege, the two status bits that widen supervisor access (user-page access permit and make-executable-readable) and the kind of access, it decides one of three things. The entry may point to the next table level. It may fault. Or it may be a valid leaf that grants the access.

For a valid leaf the block returns three things: the entry with its accessed bit set (and its dirty bit set on a store) for write-back, and the read, write and execute rights to load into a translation cache entry. The walker also supplies the superpage shift of the current level, counted in page-number bits. The block rejects a leaf whose page number is not aligned to that superpage.

The block is purely combinational. It holds no state, reads no memory and forms no physical address.

Top module: `pte_leaf_checker`

## Requirements
- R1: When entry bit 0 (valid) is 0, `fault_o` is 1 and `fault_code_o` is 3'd1.
- R2: When bit 0 is 1 and bits 1 (read), 2 (write) and 3 (execute) are all 0, `next_level_o` is 1, `fault_o` is 0, `fault_code_o` is 0 and all three permission outputs are 0.
- R3: A valid entry whose bits 3:1 are 3'b010 or 3'b110 (write without read) faults with code 3'd2.
- R4: A leaf with bit 4 (user) set faults with code 3'd3 when `priv_i` is not 2'b00 (user) and either `sum_i` is 0 or `access_i` is 2'b00 (fetch).
- R5: A leaf with bit 4 clear faults with code 3'd4 when `priv_i` is not 2'b01 (supervisor). Codes 2'b10 and 2'b11 name neither mode.
- R6: A leaf faults with code 3'd5 when any of the lowest `shift_i` bits of the page number (entry bits 53:10) is nonzero.
- R7: The access check faults with code 3'd6 in four cases. A load (`access_i` 2'b01) needs bit 1, or bit 3 with `mxr_i` set. A store (2'b10) needs bit 2. A fetch (2'b00) needs bit 3. Code 2'b11 always faults.
- R8: The checks run in the order R1, R3, R4, R5, R6, R7, and only the first one that fails sets the code. `fault_o` is 1 exactly when the code is nonzero.
- R9: `pte_upd_o` equals the entry with bit 6 set, and with bit 7 also set when the access is a store. All other bits pass through unchanged.
- R10: On a granted leaf, `rd_o` = bit 1 OR (bit 3 AND `mxr_i`) and `ex_o` = bit 3. `wr_o` = bit 2 AND (store OR bit 7). All three are 0 whenever `fault_o` or `next_level_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pte_i | input | 64 | Entry under test |
| priv_i | input | 2 | Requesting privilege: 00 user, 01 supervisor |
| sum_i | input | 1 | Permit supervisor data access to user pages |
| mxr_i | input | 1 | Let execute-only pages be read |
| access_i | input | 2 | 00 fetch, 01 load, 10 store, 11 none |
| shift_i | input | 6 | Superpage alignment, in page-number bits |
| next_level_o | output | 1 | Entry points to the next table |
| fault_o | output | 1 | Walk ends in a page fault |
| fault_code_o | output | 3 | First failing check, 0 when none |
| pte_upd_o | output | 64 | Entry with accessed/dirty bits applied |
| rd_o | output | 1 | Read right to install |
| wr_o | output | 1 | Write right to install |
| ex_o | output | 1 | Execute right to install |

## Verification
The block holds no state, so an internal fault shows on the ports in the same evaluation as the stimulus that exposes it. There is no delay to wait for. A wrong priority between rules shows only as a wrong `fault_code_o` on entries that break two rules at once. The bench therefore builds entries that fail several checks together. An over-eager write grant shows only on clean pages under loads, so loads to writable pages with and without the dirty bit are exercised deliberately.

// File: rtl/ptechk_pkg.sv
// Package: shared encodings for the leaf entry checker.
// Assumes the standard flag layout in the low byte and a page number from bit 10.
package ptechk_pkg;

    localparam int BIT_V = 0;
    localparam int BIT_R = 1;
    localparam int BIT_W = 2;
    localparam int BIT_X = 3;
    localparam int BIT_U = 4;
    localparam int BIT_A = 6;
    localparam int BIT_D = 7;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_NONE  = 2'b11
    } acc_e;

    typedef enum logic [2:0] {
        FC_NONE       = 3'd0,
        FC_INVALID    = 3'd1,
        FC_RESERVED   = 3'd2,
        FC_USER_PAGE  = 3'd3,
        FC_SUPER_PAGE = 3'd4,
        FC_MISALIGNED = 3'd5,
        FC_DENIED     = 3'd6
    } fcode_e;

endpackage

// File: rtl/ptechk_align.sv
// Module: ptechk_align
// Flags a page number whose low SHIFT bits are not all zero (misaligned superpage).
// Assumes a shift at or beyond PPN_W masks the whole page number.
module ptechk_align #(
    parameter int PPN_W   = 44,
    parameter int SHIFT_W = 6
) (
    input  logic [PPN_W-1:0]   ppn_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               misaligned_o
);

    logic [PPN_W-1:0] low_hits;

    // One compare per page-number bit: is this bit inside the superpage offset and set?
    for (genvar i = 0; i < PPN_W; i++) begin : g_bit
        assign low_hits[i] = ppn_i[i] && (32'(i) < 32'(shift_i));
    end

    // Any hit below the shift marks the entry misaligned.
    assign misaligned_o = |low_hits;

endmodule

// File: rtl/ptechk_rules.sv
// Module: ptechk_rules
// Runs the ordered fault checks on one entry and reports the first failure.
// Assumes the misalignment result comes from ptechk_align for the same entry.
module ptechk_rules
    import ptechk_pkg::*;
(
    input  logic       v_i,
    input  logic       r_i,
    input  logic       w_i,
    input  logic       x_i,
    input  logic       u_i,
    input  logic       misaligned_i,
    input  logic [1:0] priv_i,
    input  logic       sum_i,
    input  logic       mxr_i,
    input  logic [1:0] access_i,
    output logic       next_level_o,
    output fcode_e     code_o
);

    acc_e acc;
    logic rights_ok;

    // Decide whether the leaf flags cover the requested access kind.
    always_comb begin
        acc = acc_e'(access_i);
        unique case (acc)
            ACC_FETCH: rights_ok = x_i;
            ACC_LOAD:  rights_ok = r_i || (x_i && mxr_i);
            ACC_STORE: rights_ok = w_i;
            default:   rights_ok = 1'b0;
        endcase
    end

    // Walk the checks in priority order; the first one that trips names the fault.
    always_comb begin
        next_level_o = 1'b0;
        code_o       = FC_NONE;
        if (!v_i) begin
            code_o = FC_INVALID;
        end else if (!(r_i || w_i || x_i)) begin
            next_level_o = 1'b1;
        end else if (w_i && !r_i) begin
            code_o = FC_RESERVED;
        end else if (u_i && (priv_i != PRIV_U) && (!sum_i || acc == ACC_FETCH)) begin
            code_o = FC_USER_PAGE;
        end else if (!u_i && (priv_i != PRIV_S)) begin
            code_o = FC_SUPER_PAGE;
        end else if (misaligned_i) begin
            code_o = FC_MISALIGNED;
        end else if (!rights_ok) begin
            code_o = FC_DENIED;
        end
    end

endmodule

// File: rtl/ptechk_grant.sv
// Module: ptechk_grant
// Forms the write-back entry and the rights to install in a translation cache entry.
// Assumes blocked_i is high for any fault or pointer entry.
module ptechk_grant
    import ptechk_pkg::*;
#(
    parameter int PTE_W = 64
) (
    input  logic [PTE_W-1:0] pte_i,
    input  logic [1:0]       access_i,
    input  logic             mxr_i,
    input  logic             blocked_i,
    output logic [PTE_W-1:0] pte_upd_o,
    output logic             rd_o,
    output logic             wr_o,
    output logic             ex_o
);

    logic is_store;

    // Set the accessed bit always and the dirty bit on stores.
    always_comb begin
        is_store  = (acc_e'(access_i) == ACC_STORE);
        pte_upd_o = pte_i;
        pte_upd_o[BIT_A] = 1'b1;
        if (is_store) pte_upd_o[BIT_D] = 1'b1;
    end

    // Grant rights; write only when already dirty or this is the store that dirties it.
    always_comb begin
        rd_o = !blocked_i && (pte_i[BIT_R] || (pte_i[BIT_X] && mxr_i));
        ex_o = !blocked_i && pte_i[BIT_X];
        wr_o = !blocked_i && pte_i[BIT_W] && (is_store || pte_i[BIT_D]);
    end

endmodule

// File: rtl/pte_leaf_checker.sv
// Module: pte_leaf_checker (top)
// Combinational judge of one walked page-table entry: pointer, fault or granted leaf.
// Assumes 64-bit entries with the page number at bits PPN_LSB upward.
module pte_leaf_checker
    import ptechk_pkg::*;
#(
    parameter int PTE_W   = 64,
    parameter int PPN_LSB = 10,
    parameter int PPN_W   = 44,
    parameter int SHIFT_W = 6
) (
    input  logic [PTE_W-1:0]   pte_i,
    input  logic [1:0]         priv_i,
    input  logic               sum_i,
    input  logic               mxr_i,
    input  logic [1:0]         access_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               next_level_o,
    output logic               fault_o,
    output logic [2:0]         fault_code_o,
    output logic [PTE_W-1:0]   pte_upd_o,
    output logic               rd_o,
    output logic               wr_o,
    output logic               ex_o
);

    localparam int PPN_MSB = PPN_LSB + PPN_W - 1;

    logic   misaligned;
    fcode_e code;

    ptechk_align #(.PPN_W(PPN_W), .SHIFT_W(SHIFT_W)) u_align (
        .ppn_i        (pte_i[PPN_MSB:PPN_LSB]),
        .shift_i      (shift_i),
        .misaligned_o (misaligned)
    );

    ptechk_rules u_rules (
        .v_i          (pte_i[BIT_V]),
        .r_i          (pte_i[BIT_R]),
        .w_i          (pte_i[BIT_W]),
        .x_i          (pte_i[BIT_X]),
        .u_i          (pte_i[BIT_U]),
        .misaligned_i (misaligned),
        .priv_i       (priv_i),
        .sum_i        (sum_i),
        .mxr_i        (mxr_i),
        .access_i     (access_i),
        .next_level_o (next_level_o),
        .code_o       (code)
    );

    // Fault flag and code leave the block together.
    assign fault_code_o = code;
    assign fault_o      = (code != FC_NONE);

    ptechk_grant #(.PTE_W(PTE_W)) u_grant (
        .pte_i     (pte_i),
        .access_i  (access_i),
        .mxr_i     (mxr_i),
        .blocked_i (fault_o || next_level_o),
        .pte_upd_o (pte_upd_o),
        .rd_o      (rd_o),
        .wr_o      (wr_o),
        .ex_o      (ex_o)
    );

endmodule

// File: rtl/pte_leaf_checker_sva.sv
// Module: pte_leaf_checker_sva
// Port-level invariants of the entry checker, attached by bind below.
// Assumes inputs are settled; checks are skipped while any input is unknown.
module pte_leaf_checker_sva (
    input logic [63:0] pte_i,
    input logic [1:0]  priv_i,
    input logic        sum_i,
    input logic        mxr_i,
    input logic [1:0]  access_i,
    input logic [5:0]  shift_i,
    input logic        next_level_o,
    input logic        fault_o,
    input logic [2:0]  fault_code_o,
    input logic [63:0] pte_upd_o,
    input logic        rd_o,
    input logic        wr_o,
    input logic        ex_o
);

    // Check the invariants whenever the inputs are known.
    always_comb begin
        if (!$isunknown({pte_i, priv_i, sum_i, mxr_i, access_i, shift_i})) begin
            p_invalid_faults_r1:  assert (pte_i[0] || fault_o);
            p_pointer_clean_r2:   assert (!next_level_o || !(fault_o || rd_o || wr_o || ex_o));
            p_reserved_faults_r3: assert (!(pte_i[0] && pte_i[2:1] == 2'b10) || fault_o);
            p_code_matches_r8:    assert (fault_o == (fault_code_o != 3'd0));
            p_accessed_set_r9:    assert (pte_upd_o[6]);
            p_fault_no_rights_r10: assert (!fault_o || !(rd_o || wr_o || ex_o));
            p_write_needs_w_r10:  assert (!wr_o || pte_i[2]);
        end
    end

endmodule

bind pte_leaf_checker pte_leaf_checker_sva u_sva (
    .pte_i        (pte_i),
    .priv_i       (priv_i),
    .sum_i        (sum_i),
    .mxr_i        (mxr_i),
    .access_i     (access_i),
    .shift_i      (shift_i),
    .next_level_o (next_level_o),
    .fault_o      (fault_o),
    .fault_code_o (fault_code_o),
    .pte_upd_o    (pte_upd_o),
    .rd_o         (rd_o),
    .wr_o         (wr_o),
    .ex_o         (ex_o)
);

// File: tb/tb_pte_leaf_checker.sv
// Bench: directed corners plus seeded random entries against a reference function.
module tb_pte_leaf_checker;

    typedef struct packed {
        logic        nl;
        logic        f;
        logic [2:0]  code;
        logic [63:0] upd;
        logic        r;
        logic        w;
        logic        x;
    } res_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pte = '0;
    logic [1:0]  priv = 2'b00;
    logic        sum = 1'b0;
    logic        mxr = 1'b0;
    logic [1:0]  acc = 2'b00;
    logic [5:0]  shift = '0;

    logic        nl_o, f_o, rd_o, wr_o, ex_o;
    logic [2:0]  code_o;
    logic [63:0] upd_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pte_leaf_checker dut (
        .pte_i(pte), .priv_i(priv), .sum_i(sum), .mxr_i(mxr), .access_i(acc),
        .shift_i(shift), .next_level_o(nl_o), .fault_o(f_o), .fault_code_o(code_o),
        .pte_upd_o(upd_o), .rd_o(rd_o), .wr_o(wr_o), .ex_o(ex_o)
    );

    // Reference built from the requirement list.
    function automatic res_t model(logic [63:0] p, logic [1:0] pv, logic s, logic m,
                                   logic [1:0] a, logic [5:0] sh);
        res_t e;
        logic [63:0] mask;
        logic ok;
        e = '0;
        e.upd = p | 64'h40 | ((a == 2'b10) ? 64'h80 : 64'h0);
        mask = (sh >= 6'd44) ? {64{1'b1}} : ((64'd1 << sh) - 64'd1);
        case (a)
            2'b00: ok = p[3];
            2'b01: ok = p[1] | (p[3] & m);
            2'b10: ok = p[2];
            default: ok = 1'b0;
        endcase
        if (!p[0]) e.code = 3'd1;
        else if (p[3:1] == 3'b000) e.nl = 1'b1;
        else if (p[3:1] == 3'b010 || p[3:1] == 3'b110) e.code = 3'd2;
        else if (p[4] && pv != 2'b00 && (!s || a == 2'b00)) e.code = 3'd3;
        else if (!p[4] && pv != 2'b01) e.code = 3'd4;
        else if (((p >> 10) & mask & 64'hFFF_FFFF_FFFF) != 0) e.code = 3'd5;
        else if (!ok) e.code = 3'd6;
        e.f = (e.code != 3'd0);
        if (!e.f && !e.nl) begin
            e.r = p[1] | (p[3] & m);
            e.x = p[3];
            e.w = p[2] & ((a == 2'b10) | p[7]);
        end
        return e;
    endfunction

    task automatic run(string tag, logic [63:0] p, logic [1:0] pv, logic s, logic m,
                       logic [1:0] a, logic [5:0] sh);
        res_t e, g;
        @(negedge clk);
        pte = p; priv = pv; sum = s; mxr = m; acc = a; shift = sh;
        #5;
        e = model(p, pv, s, m, a, sh);
        g = '{nl_o, f_o, code_o, upd_o, rd_o, wr_o, ex_o};
        checks++;
        if (g !== e) begin
            errors++;
            $display("FAIL %s pte=%h got nl=%b f=%b c=%0d upd=%h rwx=%b%b%b exp nl=%b f=%b c=%0d upd=%h rwx=%b%b%b",
                     tag, p, g.nl, g.f, g.code, g.upd, g.r, g.w, g.x,
                     e.nl, e.f, e.code, e.upd, e.r, e.w, e.x);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Idle inputs: an all-zero entry is invalid (R1).
        run("R1", 64'h0, 2'b00, 0, 0, 2'b00, 6'd0);
        run("R1", 64'hFFFF_FFFF_FFFF_FFFE, 2'b01, 1, 1, 2'b01, 6'd0);
        // Pointer entries (R2), including stray U/A/D bits.
        run("R2", 64'h0000_0000_1234_5401, 2'b01, 0, 0, 2'b01, 6'd9);
        run("R2", 64'h0000_0000_0000_04D1, 2'b00, 1, 1, 2'b10, 6'd0);
        // Reserved write-without-read (R3), even with a bad mode.
        run("R3", 64'h0000_0000_0000_0405, 2'b01, 0, 0, 2'b10, 6'd0);
        run("R3", 64'h0000_0000_0000_041D, 2'b01, 0, 0, 2'b00, 6'd0);
        // User page rules (R4).
        run("R4", 64'h0000_0000_0000_0413, 2'b01, 0, 0, 2'b01, 6'd0);
        run("R4", 64'h0000_0000_0000_0419, 2'b01, 1, 0, 2'b00, 6'd0);
        run("R4", 64'h0000_0000_0000_0413, 2'b01, 1, 0, 2'b01, 6'd0);
        run("R4", 64'h0000_0000_0000_041B, 2'b00, 0, 0, 2'b00, 6'd0);
        run("R4", 64'h0000_0000_0000_0413, 2'b11, 0, 0, 2'b01, 6'd0);
        // Supervisor page from user and from other modes (R5).
        run("R5", 64'h0000_0000_0000_040B, 2'b00, 1, 1, 2'b00, 6'd0);
        run("R5", 64'h0000_0000_0000_0403, 2'b11, 0, 0, 2'b01, 6'd0);
        // Superpage alignment (R6).
        run("R6", 64'h0000_0000_0000_0C03, 2'b01, 0, 0, 2'b01, 6'd9);
        run("R6", 64'h0000_0000_0008_0003, 2'b01, 0, 0, 2'b01, 6'd9);
        run("R6", 64'h0000_0000_0080_0003, 2'b01, 0, 0, 2'b01, 6'd9);
        run("R6", 64'h0020_0000_0000_0003, 2'b01, 0, 0, 2'b01, 6'd63);
        // Access rights and make-executable-readable (R7).
        run("R7", 64'h0000_0000_0000_0409, 2'b01, 0, 0, 2'b01, 6'd0);
        run("R7", 64'h0000_0000_0000_0409, 2'b01, 0, 1, 2'b01, 6'd0);
        run("R7", 64'h0000_0000_0000_0403, 2'b01, 0, 0, 2'b10, 6'd0);
        run("R7", 64'h0000_0000_0000_0403, 2'b01, 0, 0, 2'b00, 6'd0);
        run("R7", 64'h0000_0000_0000_040F, 2'b01, 0, 0, 2'b11, 6'd0);
        // Priority: several rules broken at once (R8).
        run("R8", 64'h0000_0000_0000_0C15, 2'b01, 0, 0, 2'b11, 6'd9);
        run("R8", 64'h0000_0000_0000_0C13, 2'b01, 0, 0, 2'b11, 6'd9);
        run("R8", 64'h0000_0000_0000_0C03, 2'b00, 0, 0, 2'b11, 6'd9);
        // Accessed/dirty update (R9).
        run("R9", 64'hABCD_0000_0000_0307, 2'b01, 0, 0, 2'b10, 6'd0);
        run("R9", 64'hABCD_0000_0000_0307, 2'b01, 0, 0, 2'b01, 6'd0);
        // Lazy write grant (R10).
        run("R10", 64'h0000_0000_0000_0407, 2'b01, 0, 0, 2'b01, 6'd0);
        run("R10", 64'h0000_0000_0000_0487, 2'b01, 0, 0, 2'b01, 6'd0);
        run("R10", 64'h0000_0000_0000_0417, 2'b00, 0, 0, 2'b10, 6'd0);
        // Seeded random mix, biased toward leaves and small shifts.
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] p;
            logic [5:0]  sh;
            p = {$urandom, $urandom};
            if ($urandom_range(0, 3) != 0) p[0] = 1'b1;
            if ($urandom_range(0, 1) != 0) p[27:10] = '0;
            case ($urandom_range(0, 3))
                0: sh = 6'd0;
                1: sh = 6'd9;
                2: sh = 6'd18;
                default: sh = 6'($urandom_range(0, 63));
            endcase
            run("R8", p, 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), sh);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule